// File: doc/BRIEF.md
# Multi-Frame Receive Length Tracker

This block keeps the byte accounting for a receive FIFO that may hold several received frames at the same time. A live counter grows by one for every byte the receiver pushes into the FIFO. When the frame is handed over, the live count moves into a second counter that belongs to the CPU side. That counter shrinks by one for every byte the CPU pops. The live counter then starts over for the next frame. The FIFO storage is outside this block. The block only watches the write and read strobes and asks for a flush when the accounting goes wrong.

The handover has two sources. In manual mode software issues an explicit copy command after the frame's closing flag. In auto mode the closing flag itself triggers the copy and raises a read-enable pulse. Four faults are detected:
- a copy that arrives while bytes of the earlier frame are still unread;
- a read that arrives when the CPU count is already zero;
- in manual mode, data of a new frame that arrives before the copy was issued;
- in auto mode, an opening flag that arrives before the signalled frame was fully read.

The last three faults flush the FIFO and zero both counters. Each event is a one-cycle pulse that is meant for an event status register.

Top module: `rx_frame_len_tracker`

## Requirements
- R1: After reset, and after any reset applied during operation, both counters read 0 and every event output and flush_req is 0.
- R2: live_cnt rises by one on each cycle with byte_wr high. It saturates at 2^CNT_W-1 and holds there.
- R3: A copy loads cpu_cnt with the live_cnt value held before that cycle. In the same edge live_cnt restarts at 0, or at 1 if byte_wr is high in the copy cycle.
- R4: cpu_cnt falls by one on each cycle with byte_rd high while cpu_cnt is above zero.
- R5: If a copy happens while cpu_cnt is not zero, ev_underrun pulses. The count used here is cpu_cnt after any same-cycle read is taken off. The copy still takes place and no flush follows.
- R6: byte_rd while cpu_cnt is 0 pulses ev_overrun and flush_req, and clears both counters.
- R7: In manual mode (auto_copy=0), a stop flag makes a frame pending. If byte_wr arrives while a frame is pending and copy_cmd is low, ev_data_exist and flush_req pulse and both counters clear. A copy clears the pending state.
- R8: In auto mode (auto_copy=1), stop_flag performs the copy and pulses ev_read_enable. copy_cmd has no effect in this mode.
- R9: In auto mode, if start_flag arrives while cpu_cnt is still non-zero after any same-cycle read, ev_frame_err and flush_req pulse and both counters clear.
- R10: Every event and flush_req is registered. It is high for exactly the one cycle after the cycle that caused it, and the counters change on that same edge. A flush takes priority over a copy in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_wr | input | 1 | One received byte written into the FIFO |
| byte_rd | input | 1 | One byte read from the FIFO by the CPU |
| stop_flag | input | 1 | Closing flag of a frame detected |
| start_flag | input | 1 | Opening flag of a frame detected |
| copy_cmd | input | 1 | Software copy command (manual mode) |
| auto_copy | input | 1 | 1 selects auto mode, 0 selects manual mode |
| live_cnt | output | CNT_W | Bytes of the frame currently being received |
| cpu_cnt | output | CNT_W | Bytes of the handed-over frame left for the CPU |
| ev_underrun | output | 1 | Copy while the previous frame was still unread |
| ev_overrun | output | 1 | Read past the end of the handed-over frame |
| ev_data_exist | output | 1 | New frame data before a manual copy |
| ev_read_enable | output | 1 | Auto mode: a frame is ready to read |
| ev_frame_err | output | 1 | Auto mode: new frame before the read finished |
| flush_req | output | 1 | Request to empty the FIFO |

## Verification
A corrupted live or CPU count shows at the ports on the next edge. It appears as a wrong value on live_cnt or cpu_cnt. It then spreads into the next copy as a false or missing underrun, or into a false overrun flush once reads run past the real frame end. A stale pending state shows up as a wrong data-exist pulse on the first byte of the following frame. The vector walk compares both counters and all six pulses after every cycle, so any such error is reported within one cycle of the point where it reaches a port.

// File: rtl/lenacct_pkg.sv
package lenacct_pkg;

  // Event pulses produced by the accounting guard
  typedef struct packed {
    logic underrun;
    logic overrun;
    logic data_exist;
    logic read_enable;
    logic frame_err;
  } lenacct_ev_t;

  localparam lenacct_ev_t EV_NONE = '{default: 1'b0};

endpackage

// File: rtl/lenacct_live_ctr.sv
module lenacct_live_ctr #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             restart,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // Saturating increment
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v,
                                               input logic en);
    return (en && v != CNT_MAX) ? v + 1'b1 : v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (clear)   cnt <= '0;
    else if (restart) cnt <= {{(CNT_W-1){1'b0}}, inc};
    else              cnt <= sat_inc(cnt, inc);
  end

  p_live_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clear && !restart && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);

  p_live_hold_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !clear && !restart) |=> cnt == CNT_MAX);

  p_live_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !clear) |=> cnt == {{(CNT_W-1){1'b0}}, $past(inc)});

endmodule

// File: rtl/lenacct_cpu_ctr.sv
module lenacct_cpu_ctr #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] remaining
);

  // Decrement that stops at zero
  function automatic logic [CNT_W-1:0] floor_dec(input logic [CNT_W-1:0] v,
                                                 input logic en);
    return (en && v != '0) ? v - 1'b1 : v;
  endfunction

  assign remaining = floor_dec(cnt, dec);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (load)  cnt <= load_val;
    else            cnt <= remaining;
  end

  p_cpu_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear) |=> cnt == $past(load_val));

  p_cpu_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && !clear && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

  p_cpu_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !load) |=> cnt == '0);

endmodule

// File: rtl/lenacct_guard.sv
module lenacct_guard
  import lenacct_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_wr,
  input  logic             byte_rd,
  input  logic             stop_flag,
  input  logic             start_flag,
  input  logic             copy_cmd,
  input  logic             auto_copy,
  input  logic [CNT_W-1:0] cpu_cnt,
  input  logic [CNT_W-1:0] cpu_left,
  output logic             do_copy,
  output logic             do_flush,
  output lenacct_ev_t      ev_q,
  output logic             flush_q
);
  logic        pending_q;
  logic        rd_over, dex_hit, ferr_hit, copy_req;
  lenacct_ev_t ev_d;

  always_comb begin
    rd_over  = byte_rd && (cpu_cnt == '0);
    dex_hit  = !auto_copy && pending_q && byte_wr && !copy_cmd;
    ferr_hit = auto_copy && start_flag && (cpu_left != '0);
    copy_req = auto_copy ? stop_flag : copy_cmd;
    do_flush = rd_over || dex_hit || ferr_hit;
    do_copy  = copy_req && !do_flush;

    ev_d             = EV_NONE;
    ev_d.overrun     = rd_over;
    ev_d.data_exist  = dex_hit;
    ev_d.frame_err   = ferr_hit;
    ev_d.underrun    = do_copy && (cpu_left != '0);
    ev_d.read_enable = do_copy && auto_copy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      ev_q      <= EV_NONE;
      flush_q   <= 1'b0;
    end else begin
      ev_q    <= ev_d;
      flush_q <= do_flush;
      if (do_flush || auto_copy || copy_cmd) pending_q <= 1'b0;
      else if (stop_flag)                    pending_q <= 1'b1;
    end
  end

  p_underrun_noflush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_q.underrun |-> !flush_q);

  p_dex_manual_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_q.data_exist |-> (!$past(auto_copy) && $past(byte_wr) && flush_q));

  p_re_auto_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_q.read_enable |-> ($past(auto_copy) && $past(stop_flag)));

  p_ferr_auto_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_q.frame_err |-> ($past(auto_copy) && $past(start_flag) && flush_q));

  p_copy_loses_to_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> !ev_q.read_enable && !ev_q.underrun);

endmodule

// File: rtl/rx_frame_len_tracker.sv
module rx_frame_len_tracker
  import lenacct_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_wr,
  input  logic             byte_rd,
  input  logic             stop_flag,
  input  logic             start_flag,
  input  logic             copy_cmd,
  input  logic             auto_copy,
  output logic [CNT_W-1:0] live_cnt,
  output logic [CNT_W-1:0] cpu_cnt,
  output logic             ev_underrun,
  output logic             ev_overrun,
  output logic             ev_data_exist,
  output logic             ev_read_enable,
  output logic             ev_frame_err,
  output logic             flush_req
);
  // Internal events brought out by name for the checks
  logic             do_copy;
  logic             do_flush;
  logic [CNT_W-1:0] cpu_left;
  lenacct_ev_t      ev_q;

  lenacct_live_ctr #(.CNT_W(CNT_W)) u_live (
    .clk(clk), .rst_n(rst_n), .inc(byte_wr), .restart(do_copy),
    .clear(do_flush), .cnt(live_cnt)
  );

  lenacct_cpu_ctr #(.CNT_W(CNT_W)) u_cpu (
    .clk(clk), .rst_n(rst_n), .dec(byte_rd), .load(do_copy),
    .load_val(live_cnt), .clear(do_flush), .cnt(cpu_cnt),
    .remaining(cpu_left)
  );

  lenacct_guard #(.CNT_W(CNT_W)) u_guard (
    .clk(clk), .rst_n(rst_n), .byte_wr(byte_wr), .byte_rd(byte_rd),
    .stop_flag(stop_flag), .start_flag(start_flag), .copy_cmd(copy_cmd),
    .auto_copy(auto_copy), .cpu_cnt(cpu_cnt), .cpu_left(cpu_left),
    .do_copy(do_copy), .do_flush(do_flush), .ev_q(ev_q), .flush_q(flush_req)
  );

  assign ev_underrun    = ev_q.underrun;
  assign ev_overrun     = ev_q.overrun;
  assign ev_data_exist  = ev_q.data_exist;
  assign ev_read_enable = ev_q.read_enable;
  assign ev_frame_err   = ev_q.frame_err;

  p_flush_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> (live_cnt == '0 && cpu_cnt == '0));

  p_overrun_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overrun |-> ($past(byte_rd) && $past(cpu_cnt) == '0));

endmodule

// File: tb/tb_rx_frame_len_tracker.sv
module tb_rx_frame_len_tracker;
  localparam int CNT_W = 12;
  localparam int NV    = 33;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_wr = 0, byte_rd = 0, stop_flag = 0, start_flag = 0, copy_cmd = 0, auto_copy = 0;
  logic [CNT_W-1:0] live_cnt, cpu_cnt;
  logic ev_underrun, ev_overrun, ev_data_exist, ev_read_enable, ev_frame_err, flush_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  rx_frame_len_tracker #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .byte_wr(byte_wr), .byte_rd(byte_rd),
    .stop_flag(stop_flag), .start_flag(start_flag), .copy_cmd(copy_cmd),
    .auto_copy(auto_copy), .live_cnt(live_cnt), .cpu_cnt(cpu_cnt),
    .ev_underrun(ev_underrun), .ev_overrun(ev_overrun),
    .ev_data_exist(ev_data_exist), .ev_read_enable(ev_read_enable),
    .ev_frame_err(ev_frame_err), .flush_req(flush_req)
  );

  // Vector: {auto,wr,rd,stop,start,copy}, live, cpu, {unr,ovr,dex,re,ferr}, flush
  localparam logic [35:0] VEC [NV] = '{
    {6'b010000, 12'd1, 12'd0, 5'b00000, 1'b0},  // R2
    {6'b010000, 12'd2, 12'd0, 5'b00000, 1'b0},  // R2
    {6'b010000, 12'd3, 12'd0, 5'b00000, 1'b0},  // R2
    {6'b000100, 12'd3, 12'd0, 5'b00000, 1'b0},  // R7 pending
    {6'b000001, 12'd0, 12'd3, 5'b00000, 1'b0},  // R3
    {6'b010000, 12'd1, 12'd3, 5'b00000, 1'b0},  // R7 no event after copy
    {6'b001000, 12'd1, 12'd2, 5'b00000, 1'b0},  // R4
    {6'b011000, 12'd2, 12'd1, 5'b00000, 1'b0},  // R4
    {6'b000100, 12'd2, 12'd1, 5'b00000, 1'b0},  // R10 idle
    {6'b000001, 12'd0, 12'd2, 5'b10000, 1'b0},  // R5
    {6'b001000, 12'd0, 12'd1, 5'b00000, 1'b0},  // R10 pulse drops
    {6'b001000, 12'd0, 12'd0, 5'b00000, 1'b0},  // R4
    {6'b001000, 12'd0, 12'd0, 5'b01000, 1'b1},  // R6
    {6'b010000, 12'd1, 12'd0, 5'b00000, 1'b0},  // R10
    {6'b000100, 12'd1, 12'd0, 5'b00000, 1'b0},  // R7
    {6'b010000, 12'd0, 12'd0, 5'b00100, 1'b1},  // R7
    {6'b110000, 12'd1, 12'd0, 5'b00000, 1'b0},  // R8
    {6'b110000, 12'd2, 12'd0, 5'b00000, 1'b0},  // R8
    {6'b100100, 12'd0, 12'd2, 5'b00010, 1'b0},  // R8
    {6'b100001, 12'd0, 12'd2, 5'b00000, 1'b0},  // R8 copy ignored
    {6'b101000, 12'd0, 12'd1, 5'b00000, 1'b0},  // R4
    {6'b100010, 12'd0, 12'd0, 5'b00001, 1'b1},  // R9
    {6'b110000, 12'd1, 12'd0, 5'b00000, 1'b0},  // R2
    {6'b100100, 12'd0, 12'd1, 5'b00010, 1'b0},  // R8
    {6'b101000, 12'd0, 12'd0, 5'b00000, 1'b0},  // R4
    {6'b100010, 12'd0, 12'd0, 5'b00000, 1'b0},  // R9 no error
    {6'b110000, 12'd1, 12'd0, 5'b00000, 1'b0},  // R2
    {6'b000100, 12'd1, 12'd0, 5'b00000, 1'b0},  // R7
    {6'b000001, 12'd0, 12'd1, 5'b00000, 1'b0},  // R3
    {6'b010000, 12'd1, 12'd1, 5'b00000, 1'b0},  // R2
    {6'b000100, 12'd1, 12'd1, 5'b00000, 1'b0},  // R7
    {6'b001001, 12'd0, 12'd1, 5'b00000, 1'b0},  // R5 read empties old frame
    {6'b010001, 12'd1, 12'd0, 5'b10000, 1'b0}   // R3 same-cycle write
  };

  function automatic string req_of(input int i);
    case (i)
      0, 1, 2, 22, 26, 29: return "R2";
      4, 28, 32:           return "R3";
      6, 7, 11, 20, 24:    return "R4";
      9, 31:               return "R5";
      12:                  return "R6";
      3, 5, 14, 15, 27, 30: return "R7";
      16, 17, 18, 19, 23:  return "R8";
      21, 25:              return "R9";
      default:             return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [30:0] act, input logic [30:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [30:0] observed();
    return {live_cnt, cpu_cnt, ev_underrun, ev_overrun, ev_data_exist,
            ev_read_enable, ev_frame_err, flush_req};
  endfunction

  task automatic drive(input logic [5:0] v);
    {auto_copy, byte_wr, byte_rd, stop_flag, start_flag, copy_cmd} = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", observed(), 31'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][35:30]);
      @(posedge clk);
      #1;
      check(req_of(i), observed(), VEC[i][29:0] == 30'd0 ? 31'd0 : {1'b0, VEC[i][29:0]});
    end
    // Mid-run reset (R1)
    @(negedge clk);
    drive(6'b000000);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check("R1", observed(), 31'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // Saturation of the live count (R2)
    drive(6'b010000);
    repeat (4100) @(posedge clk);
    #1;
    check("R2", {19'd0, live_cnt}, {19'd0, 12'hFFF});
    @(negedge clk);
    drive(6'b000100);
    @(negedge clk);
    drive(6'b000001);
    @(posedge clk);
    #1;
    check("R3", {7'd0, live_cnt, cpu_cnt}, {7'd0, 12'd0, 12'hFFF});
    @(negedge clk);
    drive(6'b000000);
    @(posedge clk);
    #1;
    check("R10", {26'd0, ev_underrun, ev_overrun, ev_data_exist, ev_read_enable, ev_frame_err},
          31'd0);
    finish_run();
  end
endmodule